// File: doc/BRIEF.md
# SMBus Indexed Block Register Slave

This block is a two-wire serial slave that gives a bus host access to a small byte-wide register file. The host addresses it with a 7-bit slave address and then moves a run of consecutive register bytes in one transaction. The slave works in both directions, and each direction carries a byte-count byte. The core runs on the chip's system clock. It oversamples SCL and SDA through a two-flop synchronizer, finds start, repeated start and stop conditions, and drives SDA only by pulling it low.

A write carries the slave address with the write bit, a starting index and a count, followed by that many data bytes. A read first sets the index in a short write phase. The host then issues a repeated start and sends the address with the read bit. The slave answers with a count byte taken from a register that software can program, followed by register contents from the index onward. The host ends the read by answering the last byte it wants with NACK. The register contents are presented to the rest of the chip as one flat vector.

Top module: `smb_idx_slave`

## Requirements
- R1: A write transaction has this order: start, address with R/W bit 0, index N, count X, then X data bytes. The slave ACKs every byte, and the data bytes land in registers N, N+1, …, N+X-1.
- R2: In a write, data bytes after the X-th are answered with NACK and change no register. The slave then ignores the bus until the next start or stop.
- R3: A read transaction has this order: start, address with R/W bit 0, index N, repeated start, address with R/W bit 1. After this the slave first sends the contents of register 8 (the count byte), then registers N, N+1, … MSB first.
- R4: While the host ACKs, the slave keeps sending. After the host NACKs a byte, the slave releases SDA and sends nothing more until a start.
- R5: Only the low 4 bits of the index byte are used. The index advances after each data byte and wraps from 15 to 0.
- R6: A start followed by an address that does not match is not acknowledged. No byte that follows it before the next start or stop is acknowledged or written.
- R7: strap_i is sampled once, on the first clock after reset is released. A value of 0 selects address 0x6A and a value of 1 selects 0x6B. Later changes on strap_i have no effect.
- R8: A stop or start that arrives in the middle of a byte abandons the transfer. The partial byte is not written, and a new transaction after a repeated start works normally.
- R9: sda_oe changes only while SCL is low (a start or stop may only clear it).
- R10: After reset all 16 registers read as zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| strap_i | input | 1 | Address selection strap |
| regs_o | output | NREGS*8 | Register contents, register k at bits 8k+7:8k |

## Verification
The assertions assume that each SCL low and high phase lasts several system clocks longer than the two-stage synchronizer delay. Under that assumption the slave's own SDA changes always settle inside the low phase. They also assume that the host changes SDA only while SCL is low, except when it deliberately forms a start or stop. The bench's bit-banging host steps on falling clock edges with quarter-bit spacing of five clocks. It changes SDA one quarter after each SCL fall, which keeps every data change clear of the high phase. Starts and stops are formed only with SCL held high, after SDA has first been set up in the low phase.

// File: rtl/smb_idx_slave.sv
module smb_idx_slave #(
  parameter int         NREGS   = 16,
  parameter int         CNT_IDX = 8,
  parameter logic [6:0] ADDR_LO = 7'h6A,
  parameter logic [6:0] ADDR_HI = 7'h6B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic               strap_i,
  output logic [NREGS*8-1:0] regs_o
);
  localparam int IW = $clog2(NREGS);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_IDX, S_CNT, S_WDATA, S_RDATA, S_IGNORE} st_t;

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_p, sda_p;
  logic          scl_s, sda_s;
  logic          scl_rise, scl_fall, start_det, stop_det;
  st_t           st;
  logic [3:0]    bitcnt;
  logic [7:0]    sh, txs, wcnt;
  logic [IW-1:0] idx;
  logic          rw, mack, addr_sel, armed;
  logic [6:0]    my_addr;
  logic [7:0]    regs [NREGS];

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign my_addr   = addr_sel ? ADDR_HI : ADDR_LO;

  for (genvar g = 0; g < NREGS; g++) begin : g_out
    assign regs_o[g*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      sh       <= '0;
      txs      <= '0;
      wcnt     <= '0;
      idx      <= '0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
      addr_sel <= 1'b0;
      armed    <= 1'b0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      if (!armed) begin
        armed    <= 1'b1;
        addr_sel <= strap_i;
      end
      if (start_det) begin
        st     <= S_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (st != S_IDLE && st != S_IGNORE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == 4'd8) begin
            mack   <= ~sda_s;
            bitcnt <= 4'd9;
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            case (st)
              S_ADDR:
                if (sh[7:1] == my_addr) begin
                  sda_oe <= 1'b1;
                  rw     <= sh[0];
                end else begin
                  sda_oe <= 1'b0;
                  st     <= S_IGNORE;
                end
              S_IDX: begin
                idx    <= sh[IW-1:0];
                sda_oe <= 1'b1;
              end
              S_CNT: begin
                wcnt   <= sh;
                sda_oe <= 1'b1;
              end
              S_WDATA:
                if (wcnt != 8'd0) begin
                  regs[idx] <= sh;
                  idx       <= idx + 1'b1;
                  wcnt      <= wcnt - 8'd1;
                  sda_oe    <= 1'b1;
                end else begin
                  sda_oe <= 1'b0;
                  st     <= S_IGNORE;
                end
              default: sda_oe <= 1'b0;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            sda_oe <= 1'b0;
            case (st)
              S_ADDR:
                if (rw) begin
                  st     <= S_RDATA;
                  sda_oe <= ~regs[CNT_IDX][7];
                  txs    <= {regs[CNT_IDX][6:0], 1'b0};
                end else begin
                  st <= S_IDX;
                end
              S_IDX: st <= S_CNT;
              S_CNT: st <= S_WDATA;
              S_RDATA:
                if (mack) begin
                  sda_oe <= ~regs[idx][7];
                  txs    <= {regs[idx][6:0], 1'b0};
                  idx    <= idx + 1'b1;
                end else begin
                  st <= S_IGNORE;
                end
              default: st <= st;
            endcase
          end else if (st == S_RDATA && bitcnt != 4'd0) begin
            sda_oe <= ~txs[7];
            txs    <= {txs[6:0], 1'b0};
          end
        end
      end
    end
  end

  logic wr_slot;
  assign wr_slot = scl_fall && !start_det && !stop_det && bitcnt == 4'd8 && st == S_WDATA;

  assert_sda_moves_low_scl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_det || stop_det)));

  assert_ignore_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IGNORE |-> !sda_oe);

  assert_overrun_nack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_slot && wcnt == 8'd0) |=> (!sda_oe && st == S_IGNORE));

  assert_index_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_slot && wcnt != 8'd0 && idx == IW'(NREGS-1)) |=> idx == '0);

  assert_strap_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable(addr_sel));

  assert_stop_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && st == S_IDLE));
endmodule

// File: tb/smb_idx_slave_tb.sv
module smb_idx_slave_tb;
  localparam int Q = 5;
  localparam logic [6:0] A_LO = 7'h6A;
  localparam logic [6:0] A_HI = 7'h6B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic strap = 1'b0;
  logic sda_oe;
  logic sda_bus;
  logic [127:0] regs_flat;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  smb_idx_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .strap_i(strap), .regs_o(regs_flat)
  );

  int nvec = 0;
  int nerr = 0;
  int r9_bad = 0;
  bit done = 1'b0;
  logic [7:0] mdl [16];

  logic scl_prev = 1'b1, oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_prev && sda_oe != oe_prev) r9_bad++;
    scl_prev <= scl_m;
    oe_prev  <= sda_oe;
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    hold(Q); sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q); sda_m = 1'b0; hold(Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    hold(Q); sda_m = 1'b0; hold(Q); scl_m = 1'b1; hold(Q); sda_m = 1'b1; hold(Q);
  endtask

  task automatic wbits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      hold(Q); sda_m = b[7-i]; hold(Q); scl_m = 1'b1; hold(2*Q); scl_m = 1'b0;
    end
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    wbits(b, 8);
    hold(Q); sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q); ack = ~sda_bus; hold(Q); scl_m = 1'b0;
  endtask

  task automatic rbyte(output logic [7:0] b, input bit ack);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      hold(2*Q); scl_m = 1'b1; hold(Q); b = {b[6:0], sda_bus}; hold(Q); scl_m = 1'b0;
    end
    hold(Q); sda_m = ~ack; hold(Q); scl_m = 1'b1; hold(2*Q); scl_m = 1'b0; hold(Q); sda_m = 1'b1;
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] ib, input logic [7:0] x,
                        input logic [7:0] seed, input int extra, input string tag);
    bit ack;
    logic [7:0] d;
    bus_start();
    wbyte({a, 1'b0}, ack); chk(ack == 1'b1, {tag, " addr ack"}, ack, 1);
    wbyte(ib, ack);        chk(ack == 1'b1, {tag, " index ack"}, ack, 1);
    wbyte(x, ack);         chk(ack == 1'b1, {tag, " count ack"}, ack, 1);
    for (int k = 0; k < int'(x) + extra; k++) begin
      d = seed + 8'(k * 37);
      wbyte(d, ack);
      chk(ack == (k < int'(x)), {tag, " data ack"}, ack, int'(k < int'(x)));
      if (k < int'(x)) mdl[(int'(ib) + k) % 16] = d;
    end
    bus_stop();
  endtask

  task automatic rd_chk(input logic [6:0] a, input logic [7:0] n, input int cnt, input string tag);
    bit ack;
    logic [7:0] b;
    bus_start();
    wbyte({a, 1'b0}, ack); chk(ack == 1'b1, {tag, " R3 addr W ack"}, ack, 1);
    wbyte(n, ack);         chk(ack == 1'b1, {tag, " R3 index ack"}, ack, 1);
    bus_start();
    wbyte({a, 1'b1}, ack); chk(ack == 1'b1, {tag, " R3 addr R ack"}, ack, 1);
    rbyte(b, 1'b1);        chk(b == mdl[8], {tag, " R3 count byte"}, b, mdl[8]);
    for (int k = 0; k < cnt; k++) begin
      rbyte(b, k < cnt - 1);
      chk(b == mdl[(int'(n) + k) % 16], {tag, " R3 data"}, b, mdl[(int'(n) + k) % 16]);
    end
    hold(4);
    chk(sda_oe == 1'b0, {tag, " R4 released after NACK"}, sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    bit ack;
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    hold(5);
    rst_n = 1'b1;
    hold(3);
    strap = 1'b1;   // R7: change after latch must be ignored
    chk(sda_oe == 1'b0, "R10 sda released at reset", sda_oe, 0);
    chk(regs_flat == '0, "R10 registers zero", 0, 0);
    rd_chk(A_LO, 8'd0, 16, "R10 reset readback");

    // R1/R5: sweep every start index with several counts
    for (int n = 0; n < 16; n++) begin
      wr_txn(A_LO, 8'(n), 8'(1 + n % 4), 8'(n * 29 + 3), 0, "R1 sweep");
      rd_chk(A_LO, 8'((n + 15) % 16), 2 + n % 4 + 1, "R1 R5 sweep readback");
    end

    // R3: programmed count register
    wr_txn(A_LO, 8'd8, 8'd1, 8'h05, 0, "R3 set count");
    rd_chk(A_LO, 8'd3, 5, "R3 count reg");

    // R5: wrap and upper index bits ignored
    wr_txn(A_LO, 8'd15, 8'd3, 8'hC1, 0, "R5 wrap");
    wr_txn(A_LO, 8'hF3, 8'd2, 8'h77, 0, "R5 upper index bits");
    rd_chk(A_LO, 8'd14, 7, "R5 wrap readback");

    // R2: overrun bytes nacked
    wr_txn(A_LO, 8'd5, 8'd2, 8'h90, 2, "R2 overrun");
    rd_chk(A_LO, 8'd4, 5, "R2 readback");

    // R6: wrong address, then bytes that look like a valid address
    bus_start();
    wbyte({A_HI, 1'b0}, ack); chk(ack == 1'b0, "R6 mismatch nack", ack, 0);
    wbyte({A_LO, 1'b0}, ack); chk(ack == 1'b0, "R6 ignored until start", ack, 0);
    wbyte(8'd0, ack);         chk(ack == 1'b0, "R6 ignored index", ack, 0);
    wbyte(8'd1, ack);         chk(ack == 1'b0, "R6 ignored count", ack, 0);
    wbyte(8'hEE, ack);        chk(ack == 1'b0, "R6 ignored data", ack, 0);
    bus_stop();
    rd_chk(A_LO, 8'd0, 16, "R6 no change");

    // R8: stop mid byte
    bus_start();
    wbyte({A_LO, 1'b0}, ack); chk(ack, "R8 addr", ack, 1);
    wbyte(8'd2, ack);         chk(ack, "R8 index", ack, 1);
    wbyte(8'd3, ack);         chk(ack, "R8 count", ack, 1);
    wbyte(8'h3C, ack);        chk(ack, "R8 first data", ack, 1);
    mdl[2] = 8'h3C;
    wbits(8'hA5, 4);
    bus_stop();
    // R8: repeated start mid byte, then a fresh write
    bus_start();
    wbyte({A_LO, 1'b0}, ack); chk(ack, "R8 addr 2", ack, 1);
    wbyte(8'd6, ack);         chk(ack, "R8 index 2", ack, 1);
    wbyte(8'd2, ack);         chk(ack, "R8 count 2", ack, 1);
    wbits(8'h5A, 5);
    bus_start();
    wbyte({A_LO, 1'b0}, ack); chk(ack, "R8 restart addr", ack, 1);
    wbyte(8'd7, ack);         chk(ack, "R8 restart index", ack, 1);
    wbyte(8'd1, ack);         chk(ack, "R8 restart count", ack, 1);
    wbyte(8'h4B, ack);        chk(ack, "R8 restart data", ack, 1);
    mdl[7] = 8'h4B;
    bus_stop();
    rd_chk(A_LO, 8'd0, 16, "R8 readback");

    // R7: reset with strap high selects the other address
    rst_n = 1'b0; strap = 1'b1;
    hold(5);
    rst_n = 1'b1;
    hold(3);
    strap = 1'b0;
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    bus_start();
    wbyte({A_LO, 1'b0}, ack); chk(ack == 1'b0, "R7 low address rejected", ack, 0);
    bus_stop();
    wr_txn(A_HI, 8'd9, 8'd2, 8'h21, 0, "R7 high address");
    rd_chk(A_HI, 8'd8, 4, "R7 readback");

    chk(r9_bad == 0, "R9 sda_oe changed while SCL high", r9_bad, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule